// File: doc/BRIEF.md
# Analog Column Phase Clock and Write-Stall Synchronizer

This block produces the two non-overlapping phase clocks that each analog column needs. It does so by dividing a selected column clock, given as a one-cycle tick enable, by four. It also makes sure that software changes switched-capacitor settings only at the safe instant in the phase cycle. When write synchronization is on, a CPU write into the switched-capacitor register window is captured. The CPU clock enable is then pulled low, and the captured write is released to the analog block only when the next PHI1 phase begins. No CPU activity, interrupt service included, can happen in the meantime.

Each column's comparator result goes to the interrupt logic through a capture register that samples at the start of PHI2. Each column can bypass that register, so that a continuous-time result still propagates while the master clocks are stopped. Two small read/write registers hold the synchronize-enable bit and the per-column bypass bits.

Top module: `acol_phase_sync`

## Requirements
- R1: A common phase quarter counter advances by one, modulo 4, on each clock edge where `src_tick` is high, and holds otherwise. Every column's `phi1` is high exactly in quarter 0 and its `phi2` exactly in quarter 2, so the two are never high together.
- R2: After reset the quarter is 0, so `phi1` is high and `phi2` is low. `cpu_clk_en` is high, `sc_wr_stb` and `cmp_out` are low, and both configuration registers read 0.
- R3: With the synchronize-enable bit clear, a write to the switched-capacitor window (address bit 7 set) drives `sc_wr_stb` for one cycle, in the cycle after the write is accepted. `cpu_clk_en` stays high throughout.
- R4: With the synchronize-enable bit set, a switched-capacitor write drops `cpu_clk_en` in the cycle after acceptance. `sc_wr_stb` is then issued in the first cycle in which `phi1` is high following a PHI1 rise that occurs strictly after the accepting edge. A rise on the accepting edge itself does not count.
- R5: After a stalled write, `cpu_clk_en` is still low in the strobe cycle and returns high in the next cycle.
- R6: During a stall, `sc_addr` and `sc_wdata` hold the captured address and data unchanged. `sc_col` reports the target column, taken from address bit 2.
- R7: Writes outside the switched-capacitor window never stall and never produce `sc_wr_stb`, whatever the synchronize-enable setting.
- R8: The control register at address 0x64 holds the synchronize-enable bit in bit 0. The bypass register at address 0x66 holds the bypass bit of column 0 in bit 4 and that of column 1 in bit 5. All other bits read 0, and both registers reset to 0.
- R9: With bypass clear, a column's `cmp_out` changes only on the clock edge where the quarter moves from 1 to 2, taking the `cmp_in` value present at that edge.
- R10: With a column's bypass bit set, its `cmp_out` follows its `cmp_in` with no clock.
- R11: A `cpu_wr` presented while `cpu_clk_en` is low is ignored. It changes neither the pending write nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_tick | input | 1 | One-cycle enable marking each selected column clock period |
| cpu_wr | input | 1 | CPU write request |
| cpu_addr | input | 8 | CPU address, used for both writes and reads |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the configuration registers |
| cpu_clk_en | output | 1 | CPU clock enable, low while a write is stalled |
| phi1 | output | 2 | PHI1 phase per column |
| phi2 | output | 2 | PHI2 phase per column |
| sc_wr_stb | output | 1 | One-cycle write strobe to the switched-capacitor block |
| sc_addr | output | 8 | Captured write address |
| sc_wdata | output | 8 | Captured write data |
| sc_col | output | 1 | Column of the captured write |
| cmp_in | input | 2 | Raw comparator result per column |
| cmp_out | output | 2 | Comparator result per column, toward interrupt logic |

## Verification
Timing is counted from the accepting edge of a write. An unsynchronized strobe is due in the next cycle. A synchronized strobe is due 1 to 4 edges later, depending on the quarter reached at acceptance, with exactly 4 when acceptance coincides with a PHI1 rise. The clock enable returns one cycle after the strobe. The bench keeps its own quarter counter and cycle count, computes the due cycle when it issues each write, and queues it. A monitor compares every strobe against the queue head on the falling edge. Captured comparator values are checked on the quarters around the 1-to-2 transition, and bypassed values a moment after `cmp_in` changes.

// File: rtl/acol_pkg.sv
package acol_pkg;

  typedef logic [1:0] quarter_t;

  localparam quarter_t Q_PHI1 = 2'd0;
  localparam quarter_t Q_GAP1 = 2'd1;
  localparam quarter_t Q_PHI2 = 2'd2;
  localparam quarter_t Q_GAP2 = 2'd3;

  function automatic quarter_t quarter_step(input quarter_t q, input logic tick);
    return tick ? quarter_t'(q + 2'd1) : q;
  endfunction

  function automatic logic phi1_level(input quarter_t q);
    return q == Q_PHI1;
  endfunction

  function automatic logic phi2_level(input quarter_t q);
    return q == Q_PHI2;
  endfunction

  // PHI1 will rise on this edge
  function automatic logic phi1_rise_due(input quarter_t q, input logic tick);
    return tick && (q == Q_GAP2);
  endfunction

  // PHI2 will rise on this edge
  function automatic logic phi2_rise_due(input quarter_t q, input logic tick);
    return tick && (q == Q_GAP1);
  endfunction

endpackage

// File: rtl/acol_phase_gen.sv
module acol_phase_gen
  import acol_pkg::*;
#(
  parameter int unsigned NCOL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_tick,
  output logic [NCOL-1:0] phi1,
  output logic [NCOL-1:0] phi2,
  output logic            phi1_rise_evt,
  output logic            phi2_rise_evt
);

  quarter_t quarter_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quarter_q <= Q_PHI1;
    else        quarter_q <= quarter_step(quarter_q, src_tick);
  end

  assign phi1_rise_evt = phi1_rise_due(quarter_q, src_tick);
  assign phi2_rise_evt = phi2_rise_due(quarter_q, src_tick);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign phi1[c] = phi1_level(quarter_q);
    assign phi2[c] = phi2_level(quarter_q);
  end

endmodule

// File: rtl/acol_cfg_regs.sv
module acol_cfg_regs #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned NCOL = 2,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h64,
  parameter logic [AW-1:0] BYP_ADDR  = 8'h66,
  parameter int unsigned BYP_LSB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            sync_en,
  output logic [NCOL-1:0] byp,
  output logic [DW-1:0]   rdata
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_en <= 1'b0;
      byp     <= '0;
    end else if (wr_en) begin
      if (addr == CTRL_ADDR) sync_en <= wdata[0];
      if (addr == BYP_ADDR)  byp     <= wdata[BYP_LSB +: NCOL];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR)     rdata[0] = sync_en;
    else if (addr == BYP_ADDR) rdata[BYP_LSB +: NCOL] = byp;
  end

endmodule

// File: rtl/acol_wr_stall.sv
module acol_wr_stall #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 1,
  parameter int unsigned COL_LSB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          sync_en,
  input  logic          phi1_rise_evt,
  output logic          cpu_clk_en,
  output logic          wr_accept,
  output logic          sc_wr_stb,
  output logic [AW-1:0] sc_addr,
  output logic [DW-1:0] sc_wdata,
  output logic [CW-1:0] sc_col
);

  logic pending_q;
  logic in_window;

  assign in_window  = cpu_addr[AW-1];
  assign cpu_clk_en = !pending_q;
  assign wr_accept  = cpu_wr && cpu_clk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      sc_wr_stb <= 1'b0;
      sc_addr   <= '0;
      sc_wdata  <= '0;
      sc_col    <= '0;
    end else begin
      sc_wr_stb <= 1'b0;
      if (pending_q) begin
        if (sc_wr_stb)          pending_q <= 1'b0;
        else if (phi1_rise_evt) sc_wr_stb <= 1'b1;
      end else if (wr_accept && in_window) begin
        sc_addr  <= cpu_addr;
        sc_wdata <= cpu_wdata;
        sc_col   <= cpu_addr[COL_LSB +: CW];
        if (sync_en) pending_q <= 1'b1;
        else         sc_wr_stb <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/acol_cmp_sync.sv
module acol_cmp_sync #(
  parameter int unsigned NCOL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_evt,
  input  logic [NCOL-1:0] byp,
  input  logic [NCOL-1:0] cmp_in,
  output logic [NCOL-1:0] cmp_out
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q <= 1'b0;
      else if (cap_evt) cap_q <= cmp_in[c];
    end
    assign cmp_out[c] = byp[c] ? cmp_in[c] : cap_q;
  end

endmodule

// File: rtl/acol_phase_sync.sv
module acol_phase_sync #(
  parameter int unsigned NCOL = 2,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h64,
  parameter logic [AW-1:0] BYP_ADDR  = 8'h66,
  parameter int unsigned BYP_LSB = 4,
  parameter int unsigned COL_LSB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     src_tick,
  input  logic                     cpu_wr,
  input  logic [AW-1:0]            cpu_addr,
  input  logic [DW-1:0]            cpu_wdata,
  output logic [DW-1:0]            cpu_rdata,
  output logic                     cpu_clk_en,
  output logic [NCOL-1:0]          phi1,
  output logic [NCOL-1:0]          phi2,
  output logic                     sc_wr_stb,
  output logic [AW-1:0]            sc_addr,
  output logic [DW-1:0]            sc_wdata,
  output logic [$clog2(NCOL)-1:0]  sc_col,
  input  logic [NCOL-1:0]          cmp_in,
  output logic [NCOL-1:0]          cmp_out
);

  localparam int unsigned CW = $clog2(NCOL);

  // named internal events, observed by the checker
  logic            phi1_rise_evt;
  logic            phi2_rise_evt;
  logic            wr_accept;
  logic            sync_en;
  logic [NCOL-1:0] byp_q;

  acol_phase_gen #(.NCOL(NCOL)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_tick      (src_tick),
    .phi1          (phi1),
    .phi2          (phi2),
    .phi1_rise_evt (phi1_rise_evt),
    .phi2_rise_evt (phi2_rise_evt)
  );

  acol_wr_stall #(.AW(AW), .DW(DW), .CW(CW), .COL_LSB(COL_LSB)) u_stall (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr        (cpu_wr),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .sync_en       (sync_en),
    .phi1_rise_evt (phi1_rise_evt),
    .cpu_clk_en    (cpu_clk_en),
    .wr_accept     (wr_accept),
    .sc_wr_stb     (sc_wr_stb),
    .sc_addr       (sc_addr),
    .sc_wdata      (sc_wdata),
    .sc_col        (sc_col)
  );

  acol_cfg_regs #(
    .AW(AW), .DW(DW), .NCOL(NCOL),
    .CTRL_ADDR(CTRL_ADDR), .BYP_ADDR(BYP_ADDR), .BYP_LSB(BYP_LSB)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_accept),
    .addr    (cpu_addr),
    .wdata   (cpu_wdata),
    .sync_en (sync_en),
    .byp     (byp_q),
    .rdata   (cpu_rdata)
  );

  acol_cmp_sync #(.NCOL(NCOL)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (phi2_rise_evt),
    .byp     (byp_q),
    .cmp_in  (cmp_in),
    .cmp_out (cmp_out)
  );

endmodule

// File: rtl/acol_phase_sync_chk.sv
module acol_phase_sync_chk #(
  parameter int unsigned NCOL = 2,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            src_tick,
  input logic [NCOL-1:0] phi1,
  input logic [NCOL-1:0] phi2,
  input logic            phi1_rise_evt,
  input logic            phi2_rise_evt,
  input logic            cpu_clk_en,
  input logic            sc_wr_stb,
  input logic [AW-1:0]   sc_addr,
  input logic [DW-1:0]   sc_wdata,
  input logic [NCOL-1:0] byp_q,
  input logic [NCOL-1:0] cmp_out
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    // R1
    phase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phi1[c] && phi2[c]));

    // R1
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_tick |=> ($stable(phi1[c]) && $stable(phi2[c])));

    // R9
    cmp_capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_q[c] && $past(!byp_q[c]) && !$past(phi2_rise_evt)) |-> $stable(cmp_out[c]));
  end

  // R4
  stall_strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_wr_stb && !cpu_clk_en) |-> ($past(phi1_rise_evt) && phi1[0]));

  // R5
  clk_en_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_wr_stb && !cpu_clk_en) |=> cpu_clk_en);

  // R6
  held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && $past(!cpu_clk_en)) |-> ($stable(sc_addr) && $stable(sc_wdata)));

endmodule

bind acol_phase_sync acol_phase_sync_chk #(.NCOL(NCOL), .AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_tick      (src_tick),
  .phi1          (phi1),
  .phi2          (phi2),
  .phi1_rise_evt (phi1_rise_evt),
  .phi2_rise_evt (phi2_rise_evt),
  .cpu_clk_en    (cpu_clk_en),
  .sc_wr_stb     (sc_wr_stb),
  .sc_addr       (sc_addr),
  .sc_wdata      (sc_wdata),
  .byp_q         (byp_q),
  .cmp_out       (cmp_out)
);

// File: tb/acol_phase_sync_test.sv
module acol_phase_sync_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_tick = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_clk_en;
  logic [1:0] phi1, phi2;
  logic       sc_wr_stb;
  logic [7:0] sc_addr, sc_wdata;
  logic [0:0] sc_col;
  logic [1:0] cmp_in = '0;
  logic [1:0] cmp_out;

  acol_phase_sync uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_clk_en(cpu_clk_en),
    .phi1(phi1), .phi2(phi2),
    .sc_wr_stb(sc_wr_stb), .sc_addr(sc_addr), .sc_wdata(sc_wdata), .sc_col(sc_col),
    .cmp_in(cmp_in), .cmp_out(cmp_out)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int qm = 0;
  bit sync_model = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    int         due;
    bit         st;
  } item_t;
  item_t exp_q[$];

  // own phase and cycle model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) qm <= 0;
    else if (src_tick) qm <= (qm + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: every strobe must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && sc_wr_stb) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected strobe", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(cyc == it.due, it.st ? "R4 strobe cycle" : "R3 strobe cycle", cyc, it.due);
        chk(sc_addr == it.a, "R6 held address", sc_addr, it.a);
        chk(sc_wdata == it.d, "R6 held data", sc_wdata, it.d);
        chk(sc_col == it.a[2], "R6 column", sc_col, it.a[2]);
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk(cpu_clk_en == 1'b1, "R7 no stall on register write", cpu_clk_en, 1);
    if (a == 8'h64) sync_model = d[0];
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [7:0] expv, input string req);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(cpu_rdata == expv, req, cpu_rdata, expv);
  endtask

  task automatic sc_write(input logic [7:0] a, input logic [7:0] d, input bit extra);
    int acc, k, due;
    item_t it;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    acc = cyc;
    cpu_wr = 1'b0;
    if (sync_model) begin
      k = (4 - qm) % 4;
      if (k == 0) k = 4;
      due = acc + k;
      chk(cpu_clk_en == 1'b0, "R4 clock enable dropped", cpu_clk_en, 0);
    end else begin
      due = acc;
    end
    it.a = a; it.d = d; it.due = due; it.st = sync_model;
    exp_q.push_back(it);
    if (extra && sync_model) begin
      // R11: write during stall is ignored
      cpu_wr = 1'b1; cpu_addr = 8'h66; cpu_wdata = 8'hFF;
      @(negedge clk);
      cpu_wr = 1'b0;
    end
    while (cyc < due) @(negedge clk);
    chk(cpu_clk_en == !sync_model, "R5 enable in strobe cycle", cpu_clk_en, !sync_model);
    @(negedge clk);
    chk(cpu_clk_en == 1'b1, "R5 enable released", cpu_clk_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state (model quarter after one tick edge)
    chk(cpu_clk_en == 1'b1, "R2 clk_en", cpu_clk_en, 1);
    chk(sc_wr_stb == 1'b0, "R2 strobe", sc_wr_stb, 0);
    chk(cmp_out == 2'b00, "R2 cmp_out", cmp_out, 0);
    reg_read(8'h64, 8'h00, "R2 control reset");
    reg_read(8'h66, 8'h00, "R2 bypass reset");

    // R1 phases with steady tick
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(phi1 == {2{qm == 0}}, "R1 phi1", phi1, {2{qm == 0}});
      chk(phi2 == {2{qm == 2}}, "R1 phi2", phi2, {2{qm == 2}});
    end
    // R1 phases with gapped tick
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      src_tick = (i % 3) != 0;
      chk(phi1 == {2{qm == 0}}, "R1 phi1 gapped", phi1, {2{qm == 0}});
      chk(phi2 == {2{qm == 2}}, "R1 phi2 gapped", phi2, {2{qm == 2}});
    end
    @(negedge clk);
    src_tick = 1'b1;

    // R8 register map
    reg_write(8'h64, 8'hFF);
    reg_read(8'h64, 8'h01, "R8 control bits");
    reg_write(8'h66, 8'hFF);
    reg_read(8'h66, 8'h30, "R8 bypass bits");
    reg_write(8'h66, 8'h00);
    reg_write(8'h64, 8'h00);
    reg_read(8'h64, 8'h00, "R8 control cleared");

    // R3 unsynchronized writes, both columns
    sc_write(8'h81, 8'h5A, 0);
    sc_write(8'h86, 8'hC3, 0);

    // R4 R5 R6 synchronized writes at every phase offset
    reg_write(8'h64, 8'h01);
    for (int off = 0; off < 4; off++) begin
      repeat (off) @(negedge clk);
      sc_write(8'h80 | 8'(off << 1), 8'h10 + 8'(off), 0);
    end
    // R11 extra write during stall
    sc_write(8'h9C, 8'hEE, 1);
    reg_read(8'h66, 8'h00, "R11 bypass untouched");
    // R7 non-window write with sync on
    reg_write(8'h10, 8'h77);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 0);
    reg_write(8'h64, 8'h00);

    // R9 capture on quarter 1->2
    while (qm != 2) @(negedge clk);
    cmp_in = 2'b10;
    #1;
    chk(cmp_out == 2'b00, "R9 held before capture", cmp_out, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cmp_out == 2'b00, "R9 held until PHI2", cmp_out, 0);
    end
    @(negedge clk);
    chk(cmp_out == 2'b10, "R9 captured at PHI2", cmp_out, 2);

    // R10 bypass column 0
    reg_write(8'h66, 8'h10);
    while (qm != 3) @(negedge clk);
    cmp_in = 2'b01;
    #1;
    chk(cmp_out == 2'b11, "R10 col0 follows, col1 held", cmp_out, 3);
    cmp_in = 2'b00;
    #1;
    chk(cmp_out[0] == 1'b0, "R10 col0 follows low", cmp_out[0], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule